// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Controller

This block decides when a half-duplex Ethernet MAC may put a frame on the wire. It steps all of its timers on a bit-time enable, so one design serves any line rate. A pending frame first waits until carrier sense has been quiet for an unbroken listening window. It then waits a fixed commit delay, during which carrier is no longer sampled, and after that it drives transmit-enable until the data source marks the last bit.

While a frame is on the wire, the collision input is watched on every bit time. On a collision the block switches the data select to an all-ones jam pattern for a fixed number of bit times and then drops transmit-enable. It draws a truncated binary exponential back-off from a free-running LFSR and, once the back-off expires, goes through the full carrier deferral again before retrying. When the collision count of a frame exceeds a programmable limit, the block pulses an error and drops the frame.

Between two frames sent back to back, a programmable gap is enforced. If carrier stayed quiet during that gap, the next frame starts straight after it. If carrier was seen, the next frame goes through the full deferral.

Top module: `hd_tx_defer`

## Requirements
- R1: While reset is held, and after its release with no frame pending, `tx_en`, `tx_jam`, `tx_done` and `tx_err` are all 0.
- R2: When `frame_rdy` is sampled high in idle and carrier stays low, `tx_en` rises after exactly 1 + DEFER_BT + COMMIT_BT bit times.
- R3: Carrier sampled high during the DEFER_BT listening window restarts that window from zero, so the start moves later by the number of bit times already spent in the window.
- R4: Carrier sampled during the COMMIT_BT delay, or in the idle bit that accepts the request, has no effect on when `tx_en` rises.
- R5: After a frame ends with `frame_rdy` still high, `tx_en` stays low for exactly max(`ipg_bt`,1) bit times before the next frame starts. If carrier was sampled high during that gap, the next frame instead goes through the full DEFER_BT + COMMIT_BT deferral after the gap.
- R6: A collision sampled during transmission sets `tx_jam` (1 selects all-ones data) from the next cycle on, with `tx_en` kept high, for exactly JAM_BT bit times. After that, `tx_en` drops.
- R7: After the jam of collision number n, with n not past the limit, `tx_en` stays low for k*SLOT_BT + DEFER_BT + COMMIT_BT bit times (carrier quiet), where 0 <= k <= 2^min(n,BO_CAP) - 1.
- R8: The jam of collision number `retry_max`+1 of one frame is followed by a one-cycle `tx_err` pulse and no retry. Every earlier jam is followed by `tx_err` = 0.
- R9: The collision count is cleared both by a completed frame and by an abort for the retry limit, so the next frame again gets `retry_max`+1 collisions before its error.
- R10: Collision is ignored outside the transmit state: during the gap, idle, deferral and commit it neither raises `tx_jam` nor `tx_en`, nor changes the start time.
- R11: All timing counts bit-enable ticks only. With `bit_en` high one cycle in three, the deferral, the frame length and the gap keep their lengths in bit times.
- R12: A frame ends on the bit in which `frame_end` is sampled high. `tx_en` is high for exactly that many bits, and `tx_done` pulses for one cycle in the first cycle after `tx_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit time; all timers advance on it |
| frame_rdy | input | 1 | A frame is waiting to be sent |
| frame_end | input | 1 | The current bit is the last bit of the frame |
| ipg_bt | input | IPG_W | Back-to-back gap in bit times (0 acts as 1) |
| retry_max | input | RETRY_W | Retries allowed before the frame is dropped |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_en | output | 1 | Transmit enable |
| tx_jam | output | 1 | Data select: 1 sends all-ones jam instead of frame data |
| tx_done | output | 1 | One-cycle pulse on successful frame end |
| tx_err | output | 1 | One-cycle pulse when the retry limit is exceeded |

## Verification
The hardest state to reach from the ports is the retry-limit abort, and the clearing of the collision count that must follow both an abort and a success. Reaching it takes a chain of collisions, each placed in a transmit cycle, with a back-off of random length between each pair. The stimulus therefore fires each collision from the cycle in which transmit-enable is seen high, follows each random back-off until transmit-enable returns, and checks the length of that silence against an arithmetic bound instead of an exact value. The retry limit is swept from zero upward, and success, abort and success again are then interleaved under a single limit.

// File: rtl/hd_tx_defer.sv
module hd_tx_defer #(
  parameter int IPG_W     = 8,
  parameter int DEFER_BT  = 60,
  parameter int COMMIT_BT = 36,
  parameter int JAM_BT    = 32,
  parameter int SLOT_BT   = 512,
  parameter int BO_CAP    = 10,
  parameter int RETRY_W   = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               frame_rdy,
  input  logic               frame_end,
  input  logic [IPG_W-1:0]   ipg_bt,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               crs,
  input  logic               col,
  output logic               tx_en,
  output logic               tx_jam,
  output logic               tx_done,
  output logic               tx_err
);

  localparam int CNT_W = $clog2(SLOT_BT + DEFER_BT + COMMIT_BT + JAM_BT + (1 << IPG_W)) + 1;
  localparam int ATT_W = RETRY_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_DEFER, S_COMMIT, S_XMIT, S_JAM, S_BOFF, S_GAP} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ATT_W-1:0]  att;
  logic [BO_CAP-1:0] slots;
  logic [BO_CAP-1:0] bo_mask;
  logic [BO_CAP-1:0] bo_pick;
  logic [15:0]       lfsr;
  logic              crs_seen;
  logic              gap_last;
  logic              over_limit;

  always_comb
    for (int i = 0; i < BO_CAP; i++)
      bo_mask[i] = (int'(att) > i);

  assign bo_pick    = lfsr[BO_CAP-1:0] & bo_mask;
  assign gap_last   = (cnt + CNT_W'(1)) >= CNT_W'(ipg_bt);
  assign over_limit = att > ATT_W'(retry_max);
  assign tx_en      = (st == S_XMIT) || (st == S_JAM);
  assign tx_jam     = (st == S_JAM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      att      <= '0;
      slots    <= '0;
      crs_seen <= 1'b0;
      tx_done  <= 1'b0;
      tx_err   <= 1'b0;
      lfsr     <= LFSR_SEED;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_done <= 1'b0;
      tx_err  <= 1'b0;
      if (bit_en) begin
        case (st)
          S_IDLE:
            if (frame_rdy) begin
              st  <= S_DEFER;
              cnt <= '0;
            end
          S_DEFER:
            if (crs) cnt <= '0;
            else if (cnt == CNT_W'(DEFER_BT - 1)) begin
              st  <= S_COMMIT;
              cnt <= '0;
            end else cnt <= cnt + CNT_W'(1);
          S_COMMIT:
            if (cnt == CNT_W'(COMMIT_BT - 1)) begin
              st  <= S_XMIT;
              cnt <= '0;
            end else cnt <= cnt + CNT_W'(1);
          S_XMIT:
            if (col) begin
              st  <= S_JAM;
              cnt <= '0;
              att <= att + ATT_W'(1);
            end else if (frame_end) begin
              st       <= S_GAP;
              cnt      <= '0;
              att      <= '0;
              crs_seen <= 1'b0;
              tx_done  <= 1'b1;
            end
          S_JAM:
            if (cnt == CNT_W'(JAM_BT - 1)) begin
              cnt <= '0;
              if (over_limit) begin
                st       <= S_GAP;
                att      <= '0;
                crs_seen <= 1'b0;
                tx_err   <= 1'b1;
              end else if (bo_pick == '0) begin
                st <= S_DEFER;
              end else begin
                st    <= S_BOFF;
                slots <= bo_pick;
              end
            end else cnt <= cnt + CNT_W'(1);
          S_BOFF:
            if (cnt == CNT_W'(SLOT_BT - 1)) begin
              cnt <= '0;
              if (slots == BO_CAP'(1)) st <= S_DEFER;
              else slots <= slots - BO_CAP'(1);
            end else cnt <= cnt + CNT_W'(1);
          S_GAP: begin
            crs_seen <= crs_seen | crs;
            if (gap_last) begin
              cnt <= '0;
              if (!frame_rdy)           st <= S_IDLE;
              else if (crs_seen || crs) st <= S_DEFER;
              else                      st <= S_XMIT;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module hd_tx_defer_chk #(
  parameter int JAM_BT = 32
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic col,
  input logic tx_en,
  input logic tx_jam,
  input logic tx_done,
  input logic tx_err
);

  logic [15:0] jb;

  always_ff @(posedge clk) begin
    if (!rst_n) jb <= '0;
    else if (!tx_jam) jb <= '0;
    else if (bit_en) jb <= jb + 16'd1;
  end

  assert_jam_inside_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_jam |-> tx_en);

  assert_jam_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_jam) |-> $past(tx_en) && $past(col) && $past(bit_en));

  assert_jam_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_jam) |-> $past(jb) == 16'(JAM_BT - 1));

  assert_done_after_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $fell(tx_en) && !$past(tx_jam));

  assert_err_after_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> $past(tx_jam) && !tx_en && !tx_done);

  assert_clean_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !tx_jam);

endmodule

bind hd_tx_defer hd_tx_defer_chk #(.JAM_BT(JAM_BT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .col(col),
  .tx_en(tx_en), .tx_jam(tx_jam), .tx_done(tx_done), .tx_err(tx_err)
);

// File: tb/test_hd_tx_defer.sv
module test_hd_tx_defer;
  localparam int W = 6, C = 4, J = 3, S = 5, CAP = 3;

  logic clk = 0, rst_n = 0, bit_en = 0, frame_rdy = 0, frame_end = 0, crs = 0, col = 0;
  logic [3:0] ipg = 4'd2;
  logic [2:0] rmax = 3'd3;
  logic tx_en, tx_jam, tx_done, tx_err;
  logic be_q = 0;
  int n_chk = 0, n_bad = 0, be_per = 1, ph = 0;

  hd_tx_defer #(.IPG_W(4), .DEFER_BT(W), .COMMIT_BT(C), .JAM_BT(J), .SLOT_BT(S),
                .BO_CAP(CAP), .RETRY_W(3)) i_hd_tx_defer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_rdy(frame_rdy), .frame_end(frame_end),
    .ipg_bt(ipg), .retry_max(rmax), .crs(crs), .col(col),
    .tx_en(tx_en), .tx_jam(tx_jam), .tx_done(tx_done), .tx_err(tx_err));

  always #5 clk = ~clk;
  always @(posedge clk) be_q <= bit_en;

  initial forever begin
    @(negedge clk);
    ph = (ph + 1 >= be_per) ? 0 : ph + 1;
    bit_en = (ph == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_start(input int crs_edge, output int bits);
    int k;
    k = 0; bits = 0; frame_rdy = 1; crs = (crs_edge == 1);
    while (!tx_en && k < 5000) begin
      tick(); k++; bits += int'(be_q); crs = (k + 1 == crs_edge);
    end
    crs = 0;
  endtask

  task automatic xmit_frame(input int len, output int hb, output int done);
    int k;
    hb = 0; k = 0;
    while (tx_en && k < 5000) begin
      frame_end = (hb == len - 1);
      tick(); k++; hb += int'(be_q);
    end
    frame_end = 0;
    done = int'(tx_done);
  endtask

  task automatic count_low(input logic crs_first, output int bits);
    int k;
    bits = 0; k = 0; crs = crs_first;
    while (!tx_en && k < 5000) begin
      tick(); k++; bits += int'(be_q); crs = 0;
    end
  endtask

  task automatic collide(input string req, output int jbits);
    int k;
    col = 1; tick(); col = 0;
    chk({req, " jam raised"}, int'(tx_jam), 1);
    chk({req, " tx_en held in jam"}, int'(tx_en), 1);
    jbits = 0; k = 0;
    while (tx_jam && k < 5000) begin
      tick(); k++; jbits += int'(be_q);
    end
  endtask

  task automatic idle_out();
    frame_rdy = 0; frame_end = 0; col = 0; crs = 0;
    repeat (60) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b, hb, d, lo, jb, mk, bad;
    repeat (3) tick();
    chk("R1 outputs in reset", int'({tx_en, tx_jam, tx_done, tx_err}), 0);
    rst_n = 1;
    repeat (3) tick();
    chk("R1 outputs after reset", int'({tx_en, tx_jam, tx_done, tx_err}), 0);

    // R2 / R3 / R4: carrier pulse swept over every bit of the wait
    for (int j = 0; j <= W + C + 2; j++) begin
      wait_start(j, b);
      if (j >= 2 && j <= W + 1) chk($sformatf("R3 window restart crs@%0d", j), b, j + W + C);
      else if (j > W + 1)       chk($sformatf("R4 commit ignores crs@%0d", j), b, 1 + W + C);
      else                      chk($sformatf("R2 deferral latency crs@%0d", j), b, 1 + W + C);
      xmit_frame(4, hb, d);
      chk("R12 frame length", hb, 4);
      chk("R12 done pulse", d, 1);
      idle_out();
    end

    // R5: back-to-back gap sweep
    for (int g = 0; g <= 9; g++) begin
      ipg = 4'(g);
      wait_start(0, b);
      xmit_frame(3, hb, d);
      count_low(1'b0, lo);
      chk($sformatf("R5 gap ipg=%0d", g), lo, (g == 0) ? 1 : g);
      xmit_frame(2 + g, hb, d);
      chk("R12 second frame length", hb, 2 + g);
      idle_out();
    end
    ipg = 4'd4;
    wait_start(0, b);
    xmit_frame(3, hb, d);
    count_low(1'b1, lo);
    chk("R5 carrier in gap forces deferral", lo, 4 + W + C);
    xmit_frame(3, hb, d);
    idle_out();

    // R6 / R7 / R8: collision chains for each retry limit
    ipg = 4'd2;
    for (int r = 0; r <= 3; r++) begin
      rmax = 3'(r);
      wait_start(0, b);
      for (int n = 1; n <= r + 1; n++) begin
        repeat (n - 1) tick();
        collide("R6", jb);
        chk("R6 jam length", jb, J);
        chk("R6 tx_en low after jam", int'(tx_en), 0);
        if (n == r + 1) begin
          chk($sformatf("R8 error at limit r=%0d", r), int'(tx_err), 1);
          frame_rdy = 0;
          bad = 0;
          repeat (40) begin tick(); if (tx_en) bad = 1; end
          chk("R8 no retry after error", bad, 0);
        end else begin
          chk($sformatf("R8 no error n=%0d r=%0d", n, r), int'(tx_err), 0);
          count_low(1'b0, lo);
          mk = (1 << ((n < CAP) ? n : CAP)) - 1;
          d = lo - W - C;
          chk($sformatf("R7 backoff slot multiple n=%0d lo=%0d", n, lo),
              int'(d >= 0 && d % S == 0), 1);
          chk($sformatf("R7 backoff range n=%0d slots=%0d max=%0d", n, d / S, mk),
              int'(d / S <= mk), 1);
        end
      end
      idle_out();
    end

    // R9: count cleared by success and by abort
    rmax = 3'd1;
    wait_start(0, b);
    collide("R9", jb);
    chk("R9 first collision no error", int'(tx_err), 0);
    count_low(1'b0, lo);
    xmit_frame(4, hb, d);
    chk("R9 success after retry", d, 1);
    count_low(1'b0, lo);
    collide("R9", jb);
    chk("R9 count cleared by success", int'(tx_err), 0);
    count_low(1'b0, lo);
    collide("R9", jb);
    chk("R9 limit reached again", int'(tx_err), 1);
    idle_out();
    wait_start(0, b);
    collide("R9", jb);
    chk("R9 count cleared by abort", int'(tx_err), 0);
    count_low(1'b0, lo);
    xmit_frame(3, hb, d);
    chk("R9 frame after abort completes", d, 1);
    idle_out();

    // R10: collision outside transmit
    wait_start(0, b);
    xmit_frame(3, hb, d);
    frame_rdy = 0; col = 1; bad = 0;
    repeat (12) begin tick(); if (tx_en || tx_jam) bad = 1; end
    col = 0;
    chk("R10 collision in gap/idle ignored", bad, 0);
    idle_out();
    col = 1;
    wait_start(0, b);
    col = 0;
    chk("R10 collision in deferral ignored", b, 1 + W + C);
    tick();
    chk("R10 no jam at start", int'(tx_jam), 0);
    xmit_frame(3, hb, d);
    idle_out();

    // R11: one bit time every three clocks
    be_per = 3;
    ipg = 4'd3;
    repeat (6) tick();
    wait_start(0, b);
    chk("R11 deferral in bit times", b, 1 + W + C);
    xmit_frame(4, hb, d);
    chk("R11 frame length in bit times", hb, 4);
    chk("R11 done pulse", d, 1);
    count_low(1'b0, lo);
    chk("R11 gap in bit times", lo, 3);
    xmit_frame(2, hb, d);
    chk("R11 second frame length", hb, 2);
    idle_out();
    be_per = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule